// File: doc/BRIEF.md
# Asynchronous DRAM Module Controller

This block lets a simple synchronous host read and write single bytes in an asynchronous, byte-wide DRAM module. The module has a multiplexed row/column address bus. The host raises `host_req` together with a read/write flag, a linear byte address and, for writes, a data byte. It keeps these inputs steady until `host_ready` pulses for one cycle. On a read, the byte appears on `host_rdata` in that same cycle, and it stays there until the next read completes.

On the memory side the block drives the active-low row strobe, column strobe and write strobe, the multiplexed address lines, and a bidirectional byte bus with its own enable. The row and column words are not the two contiguous halves of the linear address. The row takes the low address byte, and its top lines come from the lowest upper-address bits. The column takes the middle byte, and its top lines come from the upper-address bits just above those.

A free-running interval timer requests a refresh burst. Each burst is made of groups. In each group the column strobe is held low while the row strobe pulses several times. A burst never cuts into an access that is in progress. After reset the block pulses the row strobe a few times to wake the module before it serves the host. All pulse widths and delays are parameters counted in clock cycles.

Top module: `adram_ctrl`

## Requirements
- R1: During reset and in idle, `mem_ras_n`, `mem_cas_n` and `mem_we_n` are high, `mem_dq_oe` is low and `host_ready` is low.
- R2: After reset, `mem_ras_n` makes exactly 8 low pulses with `mem_cas_n` high before the first access begins. `host_ready` stays low until then.
- R3: With `SIZE_SEL`=0 (18-bit address), the row word is {addr[16], addr[7:0]} and the column word is {addr[17], addr[15:8]}. Bit 8 of `mem_addr` is the top line.
- R4: With `SIZE_SEL`=1 or 2, the row's top lines take the 2 or 3 lowest address bits above bit 15. The column's top lines take the next 2 or 3 bits. With `SIZE_SEL`=2 this gives row = {addr[18:16], addr[7:0]} and column = {addr[21:19], addr[15:8]}.
- R5: A write runs in this order: row strobe falls; column is presented; write strobe falls and the data bus is driven; column strobe falls, then rises; the bus is released; write strobe rises; row strobe rises. The module stores `host_wdata` at the addressed row and column.
- R6: A read samples the bus `T_CAC` cycles after the column strobe falls. The row strobe rises while the column strobe is still low, and the column strobe rises after that. The sampled byte is returned on `host_rdata`.
- R7: A refresh burst is 32 groups. In each group the column strobe falls while the row strobe is high, then the row strobe makes 8 low pulses, then the column strobe rises. A burst gives 256 refresh pulses.
- R8: When the host is idle, refresh bursts start exactly every `REF_INTERVAL` clock cycles.
- R9: If the refresh timer expires during a read or write, the burst waits until that access has completed.
- R10: A pending refresh wins over a host request seen in the same idle cycle. A request made during a burst waits, with `host_ready` low, until the burst ends.
- R11: `host_ready` is high for exactly one cycle per access. `host_rdata` changes only in a cycle where `host_ready` is high, and a write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, held until `host_ready` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Linear byte address (18, 20 or 22 bits) |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Registered read data |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | MA_W | Multiplexed row/column address |
| mem_dq | inout | 8 | Module data bus |
| mem_dq_oe | output | 1 | High while the block drives `mem_dq` |

## Verification
The assertions assume that the host holds `host_req` and its qualifiers steady from the request until `host_ready`. They also assume the host drops the request in the ready cycle unless it wants another access. They rely on the memory driving `mem_dq` only while both strobes are low and the write strobe is high. The bench drives its requests from tasks that follow this handshake exactly. Its behavioural module model drives the bus only in that read window. The bench chooses `REF_INTERVAL` longer than a full burst, so the bursts never overlap.

// File: rtl/adram_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the DRAM module controller.
// Assumes: one sequencer state register; encodings are not visible outside.
package adram_pkg;
    typedef enum logic [3:0] {
        ST_INIT_LO, ST_INIT_HI, ST_IDLE,
        ST_RSET, ST_ROW, ST_COL, ST_CAS, ST_RD_RAS,
        ST_WR_CAS, ST_WR_REL, ST_WR_WE,
        ST_RF_CAS, ST_RF_LO, ST_RF_HI, ST_RF_END, ST_PRE
    } seq_state_e;
endpackage

// File: rtl/adram_addr_map.sv
`timescale 1ns/1ps
// Splits a linear byte address into row and column words.
// Assumes: MA_W = 8 + UB and ADDR_W = 16 + 2*UB; the low byte and the first
// UB upper bits form the row, the middle byte and the next UB bits the column.
module adram_addr_map #(
    parameter int UB     = 1,
    parameter int ADDR_W = 16 + 2*UB,
    parameter int MA_W   = 8 + UB
) (
    input  logic [ADDR_W-1:0] lin_addr,
    output logic [MA_W-1:0]   row_word,
    output logic [MA_W-1:0]   col_word
);
    // Interleaved slicing: upper address bits split between row and column tops.
    assign row_word = {lin_addr[16 +: UB],      lin_addr[7:0]};
    assign col_word = {lin_addr[16 + UB +: UB], lin_addr[15:8]};
endmodule

// File: rtl/adram_ref_timer.sv
`timescale 1ns/1ps
// Free-running refresh interval timer with a sticky pending flag.
// Assumes: the sequencer acknowledges once per burst; a new tick wins over an ack.
module adram_ref_timer #(
    parameter int REF_INTERVAL = 400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ack,
    output logic ref_pend
);
    localparam int TW = $clog2(REF_INTERVAL + 1);
    logic [TW-1:0] tcnt;

    // Count down, reload at zero and raise the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt     <= TW'(REF_INTERVAL - 1);
            ref_pend <= 1'b0;
        end else if (tcnt == '0) begin
            tcnt     <= TW'(REF_INTERVAL - 1);
            ref_pend <= 1'b1;
        end else begin
            tcnt <= tcnt - 1'b1;
            if (ref_ack) ref_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/adram_seq.sv
`timescale 1ns/1ps
// Strobe sequencer: wake-up pulses, read, early-write and refresh bursts.
// Assumes: host inputs stable from request to ready; all timing values >= 1.
module adram_seq import adram_pkg::*; #(
    parameter int MA_W        = 9,
    parameter int T_RCD       = 2,
    parameter int T_CAC       = 2,
    parameter int T_RAS_LO    = 5,
    parameter int T_RAS_HI    = 5,
    parameter int INIT_PULSES = 8,
    parameter int PULSES      = 8,
    parameter int GROUPS      = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_req,
    input  logic            host_we,
    input  logic [7:0]      host_wdata,
    input  logic [MA_W-1:0] row_word,
    input  logic [MA_W-1:0] col_word,
    input  logic            ref_pend,
    input  logic [7:0]      dq_in,
    output logic            ref_ack,
    output logic            host_ready,
    output logic [7:0]      host_rdata,
    output logic            ras_n,
    output logic            cas_n,
    output logic            we_n,
    output logic [MA_W-1:0] ma,
    output logic [7:0]      dq_out,
    output logic            dq_oe,
    output logic            acc_busy,
    output logic            rf_busy,
    output logic            idle_st,
    output logic            init_done
);
    localparam int CNT_W = $clog2(T_RCD + T_CAC + T_RAS_LO + T_RAS_HI + 1);
    localparam int PCW   = $clog2(PULSES + INIT_PULSES + 1);
    localparam int GCW   = $clog2(GROUPS + 1);
    localparam logic [CNT_W-1:0] LD_LO  = CNT_W'(T_RAS_LO - 1);
    localparam logic [CNT_W-1:0] LD_HI  = CNT_W'(T_RAS_HI - 1);
    localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_CAC = CNT_W'(T_CAC - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [PCW-1:0]   pcnt;
    logic [GCW-1:0]   gcnt;
    logic             wr_q;
    logic [MA_W-1:0]  row_q, col_q;
    logic [7:0]       wd_q, samp_q;
    logic             tdone;

    assign tdone = (cnt == '0);

    // State, interval counter, pulse and group counters, captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_INIT_HI;
            cnt        <= LD_HI;
            pcnt       <= '0;
            gcnt       <= '0;
            wr_q       <= 1'b0;
            row_q      <= '0;
            col_q      <= '0;
            wd_q       <= '0;
            samp_q     <= '0;
            host_rdata <= '0;
            host_ready <= 1'b0;
        end else begin
            host_ready <= 1'b0;
            if (!tdone) cnt <= cnt - 1'b1;
            case (state)
                ST_INIT_LO: if (tdone) begin
                    state <= ST_INIT_HI; cnt <= LD_HI; pcnt <= pcnt + 1'b1;
                end
                ST_INIT_HI: if (tdone) begin
                    if (pcnt == PCW'(INIT_PULSES)) begin
                        state <= ST_IDLE; pcnt <= '0;
                    end else begin
                        state <= ST_INIT_LO; cnt <= LD_LO;
                    end
                end
                ST_IDLE: if (ref_pend) begin
                    state <= ST_RF_CAS; pcnt <= '0; gcnt <= '0;
                end else if (host_req) begin
                    state <= ST_RSET; wr_q <= host_we;
                    row_q <= row_word; col_q <= col_word; wd_q <= host_wdata;
                end
                ST_RSET:   begin state <= ST_ROW; cnt <= LD_RCD; end
                ST_ROW:    if (tdone) state <= ST_COL;
                ST_COL:    begin state <= ST_CAS; cnt <= LD_CAC; end
                ST_CAS:    if (tdone) begin
                    if (wr_q) state <= ST_WR_CAS;
                    else begin state <= ST_RD_RAS; samp_q <= dq_in; end
                end
                ST_RD_RAS: begin
                    state <= ST_PRE; cnt <= LD_HI; host_ready <= 1'b1; host_rdata <= samp_q;
                end
                ST_WR_CAS: state <= ST_WR_REL;
                ST_WR_REL: state <= ST_WR_WE;
                ST_WR_WE:  begin state <= ST_PRE; cnt <= LD_HI; host_ready <= 1'b1; end
                ST_RF_CAS: begin state <= ST_RF_LO; cnt <= LD_LO; end
                ST_RF_LO:  if (tdone) begin state <= ST_RF_HI; cnt <= LD_HI; end
                ST_RF_HI:  if (tdone) begin
                    if (pcnt == PCW'(PULSES - 1)) begin
                        state <= ST_RF_END; pcnt <= '0;
                    end else begin
                        state <= ST_RF_LO; cnt <= LD_LO; pcnt <= pcnt + 1'b1;
                    end
                end
                ST_RF_END: if (gcnt == GCW'(GROUPS - 1)) begin
                    state <= ST_PRE; cnt <= LD_HI;
                end else begin
                    state <= ST_RF_CAS; gcnt <= gcnt + 1'b1;
                end
                ST_PRE:    if (tdone) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Strobe, address and bus-enable decode from the state register.
    always_comb begin
        ras_n  = !(state inside {ST_INIT_LO, ST_ROW, ST_COL, ST_CAS,
                                 ST_WR_CAS, ST_WR_REL, ST_WR_WE, ST_RF_LO});
        cas_n  = !(state inside {ST_CAS, ST_RD_RAS, ST_RF_CAS, ST_RF_LO, ST_RF_HI});
        we_n   = !(wr_q && (state inside {ST_COL, ST_CAS, ST_WR_CAS, ST_WR_REL}));
        dq_oe  = wr_q && (state inside {ST_COL, ST_CAS, ST_WR_CAS});
        ma     = (state inside {ST_RSET, ST_ROW}) ? row_q : col_q;
        dq_out = wd_q;
    end

    // Status decode used by the timer handshake and the checker.
    assign idle_st   = (state == ST_IDLE);
    assign ref_ack   = idle_st && ref_pend;
    assign acc_busy  = state inside {ST_RSET, ST_ROW, ST_COL, ST_CAS, ST_RD_RAS,
                                     ST_WR_CAS, ST_WR_REL, ST_WR_WE};
    assign rf_busy   = state inside {ST_RF_CAS, ST_RF_LO, ST_RF_HI, ST_RF_END};
    assign init_done = !(state inside {ST_INIT_LO, ST_INIT_HI});
endmodule

// File: rtl/adram_ctrl.sv
`timescale 1ns/1ps
// Top of the DRAM module controller: address map, refresh timer, sequencer,
// and the tri-state data bus.
// Assumes: SIZE_SEL 0/1/2 selects 18/20/22-bit addressing.
module adram_ctrl #(
    parameter int SIZE_SEL     = 0,
    parameter int REF_INTERVAL = 400000,
    parameter int T_RCD        = 2,
    parameter int T_CAC        = 2,
    parameter int T_RAS_LO     = 5,
    parameter int T_RAS_HI     = 5,
    localparam int UB          = SIZE_SEL + 1,
    localparam int ADDR_W      = 16 + 2*UB,
    localparam int MA_W        = 8 + UB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic              host_ready,
    output logic [7:0]        host_rdata,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [MA_W-1:0]   mem_addr,
    inout  wire  [7:0]        mem_dq,
    output logic              mem_dq_oe
);
    logic [MA_W-1:0] row_word, col_word;
    logic            ref_pend, ref_ack;
    logic [7:0]      dq_out;
    logic            acc_busy, rf_busy, idle_st, init_done;

    adram_addr_map #(.UB(UB)) u_map (
        .lin_addr (host_addr),
        .row_word (row_word),
        .col_word (col_word)
    );

    adram_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_ack  (ref_ack),
        .ref_pend (ref_pend)
    );

    adram_seq #(
        .MA_W(MA_W), .T_RCD(T_RCD), .T_CAC(T_CAC),
        .T_RAS_LO(T_RAS_LO), .T_RAS_HI(T_RAS_HI)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .row_word   (row_word),
        .col_word   (col_word),
        .ref_pend   (ref_pend),
        .dq_in      (mem_dq),
        .ref_ack    (ref_ack),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .ras_n      (mem_ras_n),
        .cas_n      (mem_cas_n),
        .we_n       (mem_we_n),
        .ma         (mem_addr),
        .dq_out     (dq_out),
        .dq_oe      (mem_dq_oe),
        .acc_busy   (acc_busy),
        .rf_busy    (rf_busy),
        .idle_st    (idle_st),
        .init_done  (init_done)
    );

    // Drive the module bus only during the write window.
    assign mem_dq = mem_dq_oe ? dq_out : 8'hzz;
endmodule

// File: rtl/adram_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the DRAM module controller, bound into every instance.
// Assumes: the host holds its request until ready (see brief).
module adram_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_req,
    input logic       host_ready,
    input logic [7:0] host_rdata,
    input logic       mem_ras_n,
    input logic       mem_cas_n,
    input logic       mem_we_n,
    input logic       mem_dq_oe,
    input logic       ref_pend,
    input logic       acc_busy,
    input logic       rf_busy,
    input logic       idle_st,
    input logic       init_done
);
    p_idle_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle_st |-> (mem_ras_n && mem_cas_n && mem_we_n && !mem_dq_oe));

    p_no_ready_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !host_ready);

    p_we_inside_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ras_n);

    p_oe_with_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    p_cbr_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ras_n) && rf_busy) |-> !mem_cas_n);

    p_refresh_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_busy && ref_pend) |=> !rf_busy);

    p_ref_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_st && ref_pend && host_req) |=> rf_busy);

    p_ready_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(host_rdata) |-> host_ready);
endmodule

bind adram_ctrl adram_ctrl_chk u_chk (.*);

// File: tb/adram_ctrl_tb_top.sv
`timescale 1ns/1ps
// Behavioural module model: latches row on RAS fall, column on CAS fall,
// counts CAS-before-RAS pulses and records refresh burst start times.
module adram_model_tb #(parameter int MA_W = 9) (
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic [MA_W-1:0] ma,
    inout wire  [7:0]      dq
);
    logic [7:0]      mem [int];
    logic [MA_W-1:0] row_q;
    logic [7:0]      rd_val;
    logic            drv;
    int    ras_falls = 0, first_snap = -1, cbr_cnt = 0, ref_cas = 0, nbursts = 0;
    longint t_prev = 0, t_last = 0;

    function automatic logic [7:0] peek(input int k);
        return mem.exists(k) ? mem[k] : 8'h00;
    endfunction

    always @(negedge ras_n) begin
        ras_falls++;
        if (cas_n) row_q = ma;
        else cbr_cnt++;
    end

    always @(negedge cas_n) begin
        if (!ras_n) begin
            if (first_snap < 0) first_snap = ras_falls;
            if (!we_n) mem[int'({row_q, ma})] = dq;
            else rd_val = peek(int'({row_q, ma}));
        end else begin
            ref_cas++;
            if (cbr_cnt % 256 == 0) begin
                t_prev = t_last; t_last = $time; nbursts++;
            end
        end
    end

    assign drv = !ras_n && !cas_n && we_n;
    assign dq  = drv ? rd_val : 8'hzz;
endmodule

module adram_ctrl_tb_top;
    localparam int RI = 3000;
    localparam int NV = 8;
    // {we, addr[21:0], data[7:0]}
    localparam logic [30:0] VEC [NV] = '{
        {1'b1, 22'h3A5C3F, 8'hA1}, {1'b1, 22'h000001, 8'h5E},
        {1'b1, 22'h2F0180, 8'hC3}, {1'b1, 22'h15AA55, 8'h0F},
        {1'b0, 22'h3A5C3F, 8'hA1}, {1'b0, 22'h15AA55, 8'h0F},
        {1'b0, 22'h000001, 8'h5E}, {1'b0, 22'h2F0180, 8'hC3}};

    logic clk = 0, rst_n = 0;
    logic req = 0, we = 0;
    logic [21:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic rdy_s, rdy_l, oe_s, oe_l;
    logic [7:0] rd_s, rd_l;
    logic ras_s, cas_s, we_s, ras_l, cas_l, we_l;
    logic [8:0]  ma_s;
    logic [10:0] ma_l;
    wire  [7:0]  dq_s, dq_l;
    int n_chk = 0, n_fail = 0, ord_err = 0, wr_evt = 0, rd_evt = 0;
    logic rd_active = 0, done = 0;

    always #5 clk = ~clk;

    adram_ctrl #(.SIZE_SEL(0), .REF_INTERVAL(RI), .T_RAS_LO(2), .T_RAS_HI(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(we), .host_addr(addr[17:0]),
        .host_wdata(wdata), .host_ready(rdy_s), .host_rdata(rd_s), .mem_ras_n(ras_s),
        .mem_cas_n(cas_s), .mem_we_n(we_s), .mem_addr(ma_s), .mem_dq(dq_s), .mem_dq_oe(oe_s));
    adram_ctrl #(.SIZE_SEL(2), .REF_INTERVAL(RI), .T_RAS_LO(2), .T_RAS_HI(2)) dut4_i (
        .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(we), .host_addr(addr),
        .host_wdata(wdata), .host_ready(rdy_l), .host_rdata(rd_l), .mem_ras_n(ras_l),
        .mem_cas_n(cas_l), .mem_we_n(we_l), .mem_addr(ma_l), .mem_dq(dq_l), .mem_dq_oe(oe_l));
    adram_model_tb #(.MA_W(9))  model0_i (.ras_n(ras_s), .cas_n(cas_s), .we_n(we_s), .ma(ma_s), .dq(dq_s));
    adram_model_tb #(.MA_W(11)) model4_i (.ras_n(ras_l), .cas_n(cas_l), .we_n(we_l), .ma(ma_l), .dq(dq_l));

    function automatic int key_s(input logic [21:0] a);
        return int'({a[16], a[7:0], a[17], a[15:8]});
    endfunction
    function automatic int key_l(input logic [21:0] a);
        return int'({a[18:16], a[7:0], a[21:19], a[15:8]});
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Edge ordering monitor on the 256K instance, sampled between clock edges.
    logic p_ras = 1, p_cas = 1, p_we = 1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!p_we && we_s) begin
                wr_evt++;
                if (oe_s || !cas_s || ras_s) ord_err++;     // R5
            end
            if (!p_cas && cas_s && !p_we && !(oe_s && !we_s)) ord_err++; // R5
            if (!p_ras && ras_s && !we_s) ord_err++;        // R5
            if (rd_active && !p_ras && ras_s) begin
                rd_evt++;
                if (cas_s) ord_err++;                       // R6
            end
            if (rd_active && !p_cas && cas_s && !ras_s) ord_err++; // R6
        end
        p_ras = ras_s; p_cas = cas_s; p_we = we_s;
    end

    task automatic do_access(input bit w, input logic [21:0] a, input logic [7:0] d,
                             output longint t_rdy);
        int waited = 0;
        @(negedge clk);
        req = 1; we = w; addr = a; wdata = d; rd_active = !w;
        while (!rdy_s && waited < 3000) begin
            @(negedge clk); waited++;
        end
        t_rdy = $time;
        chk(rdy_s && rdy_l, "R11 ready seen", {rdy_s, rdy_l}, 2'b11);
        req = 0; rd_active = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            summary();
        end
    end

    initial begin
        longint tr, s3;
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        chk(ras_s && cas_s && we_s && !oe_s && !rdy_s, "R1 reset levels",
            {ras_s, cas_s, we_s, oe_s, rdy_s}, 5'b11100);
        rst_n = 1;

        // Table-driven writes and reads on both sizes.
        for (int i = 0; i < NV; i++) begin
            do_access(VEC[i][30], VEC[i][29:8], VEC[i][7:0], tr);
            if (i == 0) chk(model0_i.first_snap == 9, "R2 wake-up pulses", model0_i.first_snap, 9);
            if (VEC[i][30]) begin
                chk(model0_i.peek(key_s(VEC[i][29:8])) == VEC[i][7:0], "R3 R5 write lands 256K",
                    model0_i.peek(key_s(VEC[i][29:8])), VEC[i][7:0]);
                chk(model4_i.peek(key_l(VEC[i][29:8])) == VEC[i][7:0], "R4 write lands 4M",
                    model4_i.peek(key_l(VEC[i][29:8])), VEC[i][7:0]);
            end else begin
                chk(rd_s == VEC[i][7:0], "R6 read data 256K", rd_s, VEC[i][7:0]);
                chk(rd_l == VEC[i][7:0], "R6 read data 4M", rd_l, VEC[i][7:0]);
            end
            @(negedge clk);
            chk(!rdy_s, "R11 single-cycle ready", rdy_s, 0);
        end

        // Rdata held across a write.
        keep = rd_s;
        do_access(1'b1, 22'h0A0B0C, 8'h77, tr);
        chk(rd_s == keep, "R11 rdata held over write", rd_s, keep);
        chk(ord_err == 0 && wr_evt == 5, "R5 write strobe order", ord_err, 0);
        chk(rd_evt == 4, "R6 read strobe order", rd_evt, 4);
        @(negedge clk);
        chk(ras_s && cas_s && we_s && !oe_s, "R1 idle levels", {ras_s, cas_s, we_s, oe_s}, 4'b1110);

        // Refresh burst structure and period while idle.
        wait (model0_i.nbursts == 2);
        chk(model0_i.cbr_cnt == 256, "R7 pulses per burst", model0_i.cbr_cnt, 256);
        chk(model0_i.ref_cas == 33, "R7 groups per burst", model0_i.ref_cas, 33);
        chk(model0_i.t_last - model0_i.t_prev == RI * 10, "R8 burst period",
            model0_i.t_last - model0_i.t_prev, RI * 10);

        // Timer expiry lands inside an access: burst must wait.
        wait (model0_i.nbursts == 3);
        s3 = model0_i.t_last;
        repeat (2994) @(negedge clk);
        do_access(1'b0, 22'h2F0180, 8'h00, tr);
        chk(rd_s == 8'hC3, "R9 read beside refresh", rd_s, 8'hC3);
        wait (model0_i.nbursts == 4);
        chk(model0_i.t_last > tr && model0_i.t_last - s3 > RI * 10, "R9 burst deferred",
            model0_i.t_last - s3, RI * 10 + 1);

        // Request during a burst waits until the burst ends.
        do_access(1'b0, 22'h15AA55, 8'h00, tr);
        chk(model0_i.cbr_cnt == 1024, "R10 request waits for burst", model0_i.cbr_cnt, 1024);
        chk(rd_s == 8'h0F, "R10 data after burst", rd_s, 8'h0F);

        done = 1;
        summary();
    end
endmodule